// File: doc/BRIEF.md
# Stepper Bridge Enable and Protection Supervisor

This block decides, every clock cycle, whether each H-bridge of a two-winding stepper driver may conduct. It also decides whether the step indexer must return to its home position, whether step pulses may be taken, and whether the clocks and the gate-drive charge pump should run. It merges an output-disable input, a low-power nap input, an indexer-clear input, per-bridge overcurrent flags, an over-temperature flag and two supply-low flags. Current, temperature and voltage sensing happen elsewhere and arrive here as digital levels.

An overcurrent flag must persist for a qualifying number of cycles before the affected bridge alone is shut off. The shutdown ends when a retry interval expires. It also ends early when the output-disable input is seen high and then low again. A heat fault or a supply fault also forces the indexer home. After a nap ends, or after supplies recover, a wake interval measured in timebase ticks must pass before stepping and driving resume.

Top module: `stepdrv_supervisor`

## Requirements
- R1: While `drive_dis_i` is 1, every bit of `bridge_on_o` is 0, and `step_hold_o` stays 0 when no other condition holds it.
- R2: While `nap_n_i` is 0, `pump_run_o`=0, `step_hold_o`=1, `home_req_o`=0 and `bridge_on_o`=0, whatever `idx_clr_n_i`, `drive_dis_i` and `oc_hit_i` do.
- R3: While awake with `idx_clr_n_i`=0, `home_req_o`=1, `step_hold_o`=1 and `bridge_on_o`=0; releasing it restores the bridges at once.
- R4: `oc_hit_i[i]` sampled high on fewer than DEG_CYC consecutive edges has no effect. Sampled high on DEG_CYC consecutive edges, it clears `bridge_on_o[i]` after the last of them, and the other bridge keeps running.
- R5: A shut-off bridge re-enables by itself after RETRY_CYC clock edges counted from the edge that shut it off.
- R6: While a bridge is shut off, `drive_dis_i` sampled 1 on one edge and 0 on a later edge ends the shutdown at that later edge.
- R7: `hot_i`=1 clears `bridge_on_o` and sets `home_req_o` while `pump_run_o` stays 1. Clearing it restores the bridges in the same cycle.
- R8: `vmot_low_i` or `vlog_low_i` at 1 gives `pump_run_o`=0, `home_req_o`=1, `step_hold_o`=1 and `bridge_on_o`=0. Operation resumes only when both flags are 0, and then after a wake interval.
- R9: When the block becomes awake, `step_hold_o`=1 and `bridge_on_o`=0 until WAKE_TICKS `wake_tick_i` pulses have been sampled on edges after the first awake edge. Without ticks, the hold does not end.
- R10: A supply fault discards any pending overcurrent shutdown.
- R11: When the retry re-enables a bridge while its overcurrent flag is still 1, the bridge runs for a full DEG_CYC-edge qualifying window before it shuts off again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_dis_i | input | 1 | 1 = bridges off (high impedance) |
| nap_n_i | input | 1 | 0 = low-power nap |
| idx_clr_n_i | input | 1 | 0 = clear indexer to home, bridges off |
| oc_hit_i | input | NB | Overcurrent flag, bit i = bridge i |
| hot_i | input | 1 | Over-temperature flag |
| vmot_low_i | input | 1 | Motor supply below threshold |
| vlog_low_i | input | 1 | Logic supply below threshold |
| wake_tick_i | input | 1 | Timebase tick for the wake interval |
| bridge_on_o | output | NB | Bit i = bridge i may conduct |
| home_req_o | output | 1 | Force indexer to home position |
| step_hold_o | output | 1 | Step pulses must be ignored |
| pump_run_o | output | 1 | Clocks and charge pump run |

## Verification
Two functions can collide in one cycle. The first is the retry expiry of an overcurrent shutdown and a fault flag that is still asserted. The bench holds the flag high across the expiry and expects the bridge back for exactly DEG_CYC cycles before it shuts off again. The second is a supply fault and a pending shutdown. The bench trips a bridge, raises a supply flag well before the retry would end, and expects that bridge to run once the wake interval after recovery has passed.

// File: rtl/stepdrv_sup_pkg.sv
package stepdrv_sup_pkg;
  typedef enum logic {
    OC_WATCH = 1'b0,
    OC_SHUT  = 1'b1
  } oc_state_e;
endpackage

// File: rtl/stepdrv_oc_guard.sv
module stepdrv_oc_guard
  import stepdrv_sup_pkg::*;
#(
  parameter int DEG_CYC   = 75,
  parameter int RETRY_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic live_i,
  input  logic flush_i,
  input  logic hit_i,
  input  logic drive_dis_i,
  output logic shut_o
);
  localparam int DW = $clog2(DEG_CYC + 1);
  localparam int RW = $clog2(RETRY_CYC + 1);

  oc_state_e       st_q, st_d;
  logic [DW-1:0]   deg_q, deg_d;
  logic [RW-1:0]   ret_q, ret_d;
  logic            seen_q, seen_d;
  logic            upd;

  assign upd = live_i | flush_i;

  always_comb begin
    st_d   = st_q;
    deg_d  = deg_q;
    ret_d  = ret_q;
    seen_d = seen_q;
    if (flush_i) begin
      st_d   = OC_WATCH;
      deg_d  = '0;
      ret_d  = '0;
      seen_d = 1'b0;
    end else begin
      case (st_q)
        OC_WATCH: begin
          if (hit_i) begin
            if (deg_q == DW'(DEG_CYC - 1)) begin
              st_d   = OC_SHUT;
              deg_d  = '0;
              ret_d  = '0;
              seen_d = 1'b0;
            end else begin
              deg_d = deg_q + DW'(1);
            end
          end else begin
            deg_d = '0;
          end
        end
        default: begin
          if ((ret_q == RW'(RETRY_CYC - 1)) || (seen_q && !drive_dis_i)) begin
            st_d   = OC_WATCH;
            ret_d  = '0;
            seen_d = 1'b0;
          end else begin
            ret_d = ret_q + RW'(1);
            if (drive_dis_i) seen_d = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OC_WATCH;
      deg_q  <= '0;
      ret_q  <= '0;
      seen_q <= 1'b0;
    end else if (upd) begin
      st_q   <= st_d;
      deg_q  <= deg_d;
      ret_q  <= ret_d;
      seen_q <= seen_d;
    end
  end

  assign shut_o = (st_q == OC_SHUT);
endmodule

// File: rtl/stepdrv_wake_timer.sv
module stepdrv_wake_timer #(
  parameter int WAKE_TICKS = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic awake_i,
  input  logic tick_i,
  output logic ready_o
);
  localparam int CW = $clog2(WAKE_TICKS + 1);

  logic          awake_q;
  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!awake_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (!awake_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q && tick_i) begin
      if (cnt_q == CW'(WAKE_TICKS - 1)) busy_d = 1'b0;
      else                              cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      awake_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      awake_q <= awake_i;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
    end
  end

  assign ready_o = awake_i & awake_q & ~busy_q;
endmodule

// File: rtl/stepdrv_supervisor.sv
module stepdrv_supervisor #(
  parameter int NB         = 2,
  parameter int DEG_CYC    = 75,
  parameter int RETRY_CYC  = 40000,
  parameter int WAKE_TICKS = 1500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drive_dis_i,
  input  logic          nap_n_i,
  input  logic          idx_clr_n_i,
  input  logic [NB-1:0] oc_hit_i,
  input  logic          hot_i,
  input  logic          vmot_low_i,
  input  logic          vlog_low_i,
  input  logic          wake_tick_i,
  output logic [NB-1:0] bridge_on_o,
  output logic          home_req_o,
  output logic          step_hold_o,
  output logic          pump_run_o
);
  logic          supply_bad;
  logic          awake;
  logic          ready;
  logic          drive_ok;
  logic [NB-1:0] shut;

  assign supply_bad = vmot_low_i | vlog_low_i;
  assign awake      = nap_n_i & ~supply_bad;

  stepdrv_wake_timer #(.WAKE_TICKS(WAKE_TICKS)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .awake_i (awake),
    .tick_i  (wake_tick_i),
    .ready_o (ready)
  );

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bridge
      stepdrv_oc_guard #(.DEG_CYC(DEG_CYC), .RETRY_CYC(RETRY_CYC)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .live_i      (awake),
        .flush_i     (supply_bad),
        .hit_i       (oc_hit_i[b]),
        .drive_dis_i (drive_dis_i),
        .shut_o      (shut[b])
      );
      assign bridge_on_o[b] = drive_ok & ~shut[b];
    end
  endgenerate

  assign drive_ok    = ready & idx_clr_n_i & ~drive_dis_i & ~hot_i;
  assign pump_run_o  = awake;
  assign step_hold_o = ~ready | ~idx_clr_n_i;
  assign home_req_o  = supply_bad | hot_i | (nap_n_i & ~idx_clr_n_i);
endmodule

// File: rtl/stepdrv_supervisor_chk.sv
module stepdrv_supervisor_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          drive_dis_i,
  input logic          nap_n_i,
  input logic          idx_clr_n_i,
  input logic          hot_i,
  input logic          vmot_low_i,
  input logic          vlog_low_i,
  input logic [NB-1:0] bridge_on_o,
  input logic          home_req_o,
  input logic          step_hold_o,
  input logic          pump_run_o
);
  assert_disable_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    drive_dis_i |-> (bridge_on_o == '0));

  assert_nap_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !nap_n_i |-> (!pump_run_o && step_hold_o && bridge_on_o == '0));

  assert_clear_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nap_n_i && !idx_clr_n_i) |-> (home_req_o && step_hold_o && bridge_on_o == '0));

  assert_hot_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hot_i |-> (home_req_o && bridge_on_o == '0));

  assert_supply_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vmot_low_i || vlog_low_i) |-> (home_req_o && !pump_run_o && step_hold_o));

  assert_wake_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nap_n_i) && !vmot_low_i && !vlog_low_i) |=> step_hold_o);
endmodule

bind stepdrv_supervisor stepdrv_supervisor_chk #(.NB(NB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .drive_dis_i (drive_dis_i),
  .nap_n_i     (nap_n_i),
  .idx_clr_n_i (idx_clr_n_i),
  .hot_i       (hot_i),
  .vmot_low_i  (vmot_low_i),
  .vlog_low_i  (vlog_low_i),
  .bridge_on_o (bridge_on_o),
  .home_req_o  (home_req_o),
  .step_hold_o (step_hold_o),
  .pump_run_o  (pump_run_o)
);

// File: tb/stepdrv_supervisor_test.sv
`timescale 1ns/1ps
module stepdrv_supervisor_test;
  localparam int NB = 2;
  localparam int DG = 4;
  localparam int RT = 20;
  localparam int WK = 8;

  // expected vector order: {pump_run, step_hold, home_req, bridge1, bridge0}
  localparam logic [4:0] ASLEEP  = 5'b01000;
  localparam logic [4:0] WAKING  = 5'b11000;
  localparam logic [4:0] RUNNING = 5'b10011;
  localparam logic [4:0] SUPPLY  = 5'b01100;

  logic clk = 1'b0;
  logic rst_n;
  logic drv_dis, nap_n, clr_n, hot, vm_low, vl_low, tick;
  logic [NB-1:0] oc;
  logic [NB-1:0] br_on;
  logic home, hold, pump;

  typedef struct {
    string      req;
    logic [4:0] exp;
  } sb_item_t;
  sb_item_t sb_q[$];

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  stepdrv_supervisor #(.NB(NB), .DEG_CYC(DG), .RETRY_CYC(RT), .WAKE_TICKS(WK)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .drive_dis_i (drv_dis),
    .nap_n_i     (nap_n),
    .idx_clr_n_i (clr_n),
    .oc_hit_i    (oc),
    .hot_i       (hot),
    .vmot_low_i  (vm_low),
    .vlog_low_i  (vl_low),
    .wake_tick_i (tick),
    .bridge_on_o (br_on),
    .home_req_o  (home),
    .step_hold_o (hold),
    .pump_run_o  (pump)
  );

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      sb_item_t it;
      logic [4:0] got;
      it  = sb_q.pop_front();
      got = {pump, hold, home, br_on};
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s: got %b expected %b", it.req, got, it.exp);
      end
    end
  end

  task automatic expect_out(input string req, input logic [4:0] e);
    sb_q.push_back('{req: req, exp: e});
    @(negedge clk);
    #1;
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wake_run(input string req);
    for (int k = 0; k <= WK; k++) begin
      expect_out(req, WAKING);
      cyc();
    end
    expect_out(req, RUNNING);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; drv_dis = 1'b1; nap_n = 1'b0; clr_n = 1'b1;
    hot = 1'b0; vm_low = 1'b0; vl_low = 1'b0; tick = 1'b1; oc = '0;
    cyc(); cyc();
    expect_out("R2 reset state", ASLEEP);
    cyc();
    rst_n = 1'b1;
    cyc();
    // R2: inputs ignored while napping
    clr_n = 1'b0; drv_dis = 1'b0; oc = 2'b11;
    expect_out("R2 nap ignores inputs", ASLEEP);
    for (int k = 0; k < DG + 2; k++) cyc();
    expect_out("R2 nap ignores overcurrent", ASLEEP);
    cyc();
    clr_n = 1'b1; oc = '0;
    cyc();
    // R9: wake interval
    nap_n = 1'b1;
    wake_run("R9 wake interval");
    cyc();
    // R1
    drv_dis = 1'b1;
    expect_out("R1 disable", 5'b10000);
    cyc();
    drv_dis = 1'b0;
    expect_out("R1 re-enable", RUNNING);
    cyc();
    // R3
    clr_n = 1'b0;
    expect_out("R3 clear", 5'b11100);
    cyc();
    clr_n = 1'b1;
    expect_out("R3 release", RUNNING);
    cyc();
    // R4 short pulse
    oc[0] = 1'b1;
    for (int k = 0; k < DG - 1; k++) begin
      expect_out("R4 short pulse", RUNNING);
      cyc();
    end
    oc[0] = 1'b0;
    expect_out("R4 short pulse no trip", RUNNING);
    cyc();
    expect_out("R4 short pulse no trip", RUNNING);
    cyc();
    // R4 full qualify, R5 retry, R11 requalify
    oc[0] = 1'b1;
    for (int k = 0; k < DG; k++) begin
      expect_out("R4 qualifying", RUNNING);
      cyc();
    end
    expect_out("R4 trip bridge0 only", 5'b10010);
    for (int j = 1; j < RT; j++) begin
      cyc();
      expect_out("R5 retry wait", 5'b10010);
    end
    cyc();
    expect_out("R5 retry end", RUNNING);
    for (int k = 1; k < DG; k++) begin
      cyc();
      expect_out("R11 requalify window", RUNNING);
    end
    cyc();
    expect_out("R11 trip again", 5'b10010);
    oc[0] = 1'b0;
    cyc();
    // R10: supply fault drops pending shutdown
    vm_low = 1'b1;
    expect_out("R10 supply fault", SUPPLY);
    cyc();
    vm_low = 1'b0;
    wake_run("R10 shutdown discarded");
    cyc();
    // R6 enable toggle clears bridge1
    oc[1] = 1'b1;
    for (int k = 0; k < DG; k++) cyc();
    expect_out("R6 trip bridge1", 5'b10001);
    oc[1] = 1'b0;
    cyc();
    drv_dis = 1'b1;
    expect_out("R6 toggle high", 5'b10000);
    cyc();
    drv_dis = 1'b0;
    expect_out("R6 toggle low before edge", 5'b10001);
    cyc();
    expect_out("R6 cleared by toggle", RUNNING);
    cyc();
    // R7
    hot = 1'b1;
    expect_out("R7 heat fault", 5'b10100);
    cyc();
    expect_out("R7 heat fault held", 5'b10100);
    cyc();
    hot = 1'b0;
    expect_out("R7 resume", RUNNING);
    cyc();
    // R8 both supplies needed
    vm_low = 1'b1; vl_low = 1'b1;
    expect_out("R8 both low", SUPPLY);
    cyc();
    vl_low = 1'b0;
    expect_out("R8 motor still low", SUPPLY);
    cyc();
    expect_out("R8 motor still low", SUPPLY);
    cyc();
    vm_low = 1'b0;
    wake_run("R8 recover with wake");
    cyc();
    vl_low = 1'b1;
    expect_out("R8 logic low", SUPPLY);
    cyc();
    vl_low = 1'b0;
    wake_run("R8 logic recover");
    cyc();
    // R9 no ticks, no end of hold
    nap_n = 1'b0;
    expect_out("R2 nap again", ASLEEP);
    cyc();
    tick = 1'b0;
    nap_n = 1'b1;
    for (int k = 0; k < 3 * WK; k++) begin
      expect_out("R9 no ticks", WAKING);
      cyc();
    end
    tick = 1'b1;
    for (int k = 0; k < WK; k++) begin
      expect_out("R9 ticks resume", WAKING);
      cyc();
    end
    expect_out("R9 ready after ticks", RUNNING);
    cyc();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule